// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block follows the progress of a control transfer on endpoint 0 of a USB device. It is fed by the packet layer. Its inputs are single-cycle strobes for SETUP, IN and OUT tokens, a strobe for every ACK handshake the device sends or receives, and the request-type byte and length field taken from the setup packet. It keeps a three-bit stage code that software can read at any time. It raises a sticky interrupt flag when the transfer crosses a protocol boundary: the setup packet is acknowledged, the status stage is opened by a token of the opposite direction, the status handshake ends the transfer, or the token order breaks the protocol.

Four of these causes can be masked one by one through a small register write port. The flag is cleared by software writing a zero to it. The stage code, a level error output and the enable mask are visible on the ports. The block does no serialisation, CRC checking, buffering or request decoding. It only consumes tokens and handshakes that have already been decoded.

Top module: `ctl_stage_tracker`

## Requirements
- R1: After reset the stage code is 000, the flag is 0 and the enable mask is 0000.
- R2: An ACK while a SETUP is pending completes the setup stage and always sets the flag. The next stage is chosen from the length and request-type inputs sampled in that cycle. A zero length gives 101, the no-data status stage. A non-zero length with request-type bit 7 set gives 001, read data. A non-zero length with bit 7 clear gives 011, write data. The code 111 is never produced.
- R3: In stage 011, OUT tokens leave the stage unchanged. An IN token moves it to 100, the write status stage, and sets the flag when enable bit 0 is 1.
- R4: In stage 001, IN tokens leave the stage unchanged. An OUT token moves it to 010, the read status stage, and sets the flag when enable bit 1 is 1.
- R5: An ACK in stage 010, 100 or 101 ends the transfer. The stage returns to 000 and the flag is set when enable bit 2 is 1.
- R6: Any of the following moves the stage to 110: an IN or OUT token in stage 000, an IN token in 010, or an OUT token in 100 or 101. The flag is then set when enable bit 3 is 1, and seq_err is high. Stage 110 holds until the next SETUP.
- R7: A SETUP token in any stage returns the stage to 000 and arms the setup stage. The SETUP token does not change the flag.
- R8: The flag is sticky. A write to address 1 with data bit 0 equal to 0 clears it. A write to address 1 with bit 0 equal to 1 changes nothing.
- R9: When a flag-setting event and a clearing write fall in the same cycle, the flag ends up set.
- R10: A write to address 0 loads data bits 3:0 into the enable mask, which is shown on cause_en. The event in that cycle still uses the old mask. A masked cause moves the stage but leaves the flag unchanged.
- R11: The following change neither the stage nor the flag: an ACK in a data stage, an ACK in stage 000 without a pending SETUP, a repeated OUT in stage 010, a repeated IN in stage 100 or 101, and a token in stage 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_setup | input | 1 | SETUP token strobe |
| tok_in | input | 1 | IN token strobe |
| tok_out | input | 1 | OUT token strobe |
| hs_ack | input | 1 | ACK handshake sent or received strobe |
| req_type | input | RT_W | Request-type byte of the setup packet; top bit is direction |
| req_len | input | LEN_W | Length field of the setup packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 enable mask, 1 flag |
| reg_wdata | input | DATA_W | Register write data |
| stage | output | 3 | Current stage code |
| xfer_irq | output | 1 | Sticky stage-transition interrupt flag |
| seq_err | output | 1 | High while in the sequence-error stage |
| cause_en | output | 4 | Enable mask: bit 0 write status, 1 read status, 2 completion, 3 error |

## Verification
A hardware set of the flag and the software clearing write can land on the same clock edge. The bench provokes this in two ways. It issues the status-opening IN token together with a flag-clear write, under every one of the sixteen enable masks. It also issues the setup ACK together with a clear. The expected flag after the edge is the enable bit of that cause, or 1 for the setup case. The sweep therefore shows the set winning when the cause is enabled and the clear taking effect when it is masked.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;

    typedef enum logic [2:0] {
        STG_IDLE    = 3'b000,
        STG_RD_DATA = 3'b001,
        STG_RD_STAT = 3'b010,
        STG_WR_DATA = 3'b011,
        STG_WR_STAT = 3'b100,
        STG_ND_STAT = 3'b101,
        STG_SEQ_ERR = 3'b110
    } stage_e;

    localparam int CAUSE_N    = 4;
    localparam int CZ_WR_STAT = 0;
    localparam int CZ_RD_STAT = 1;
    localparam int CZ_DONE    = 2;
    localparam int CZ_ERR     = 3;

    typedef struct packed {
        stage_e stage;
        logic   armed;
    } seq_state_t;

    typedef struct packed {
        logic               setup_done;
        logic [CAUSE_N-1:0] hit;
    } cause_t;

    typedef struct packed {
        logic [CAUSE_N-1:0] en;
        logic               flag;
    } irq_state_t;

endpackage

// File: rtl/ctl_stage_seq.sv
module ctl_stage_seq
    import ctl_stage_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int RT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_setup,
    input  logic             tok_in,
    input  logic             tok_out,
    input  logic             hs_ack,
    input  logic [RT_W-1:0]  req_type,
    input  logic [LEN_W-1:0] req_len,
    output stage_e           stage,
    output cause_t           cause
);
    localparam int DIR_BIT = RT_W - 1;

    seq_state_t s_d, s_q;
    logic       len_zero;
    logic       dir_to_host;

    assign len_zero    = (req_len == '0);
    assign dir_to_host = req_type[DIR_BIT];

    generate
        if (RT_W > 1) begin : g_rt_spare
            logic unused_rt;
            assign unused_rt = ^req_type[DIR_BIT-1:0];
        end
    endgenerate

    always_comb begin
        s_d   = s_q;
        cause = '0;
        if (tok_setup) begin
            s_d.stage = STG_IDLE;
            s_d.armed = 1'b1;
        end else begin
            unique case (s_q.stage)
                STG_IDLE: begin
                    if (tok_in || tok_out) begin
                        s_d.stage          = STG_SEQ_ERR;
                        s_d.armed          = 1'b0;
                        cause.hit[CZ_ERR]  = 1'b1;
                    end else if (hs_ack && s_q.armed) begin
                        s_d.armed        = 1'b0;
                        cause.setup_done = 1'b1;
                        if (len_zero)
                            s_d.stage = STG_ND_STAT;
                        else if (dir_to_host)
                            s_d.stage = STG_RD_DATA;
                        else
                            s_d.stage = STG_WR_DATA;
                    end
                end
                STG_RD_DATA: begin
                    if (tok_out) begin
                        s_d.stage             = STG_RD_STAT;
                        cause.hit[CZ_RD_STAT] = 1'b1;
                    end
                end
                STG_WR_DATA: begin
                    if (tok_in) begin
                        s_d.stage             = STG_WR_STAT;
                        cause.hit[CZ_WR_STAT] = 1'b1;
                    end
                end
                STG_RD_STAT: begin
                    if (tok_in) begin
                        s_d.stage         = STG_SEQ_ERR;
                        cause.hit[CZ_ERR] = 1'b1;
                    end else if (hs_ack) begin
                        s_d.stage          = STG_IDLE;
                        cause.hit[CZ_DONE] = 1'b1;
                    end
                end
                STG_WR_STAT, STG_ND_STAT: begin
                    if (tok_out) begin
                        s_d.stage         = STG_SEQ_ERR;
                        cause.hit[CZ_ERR] = 1'b1;
                    end else if (hs_ack) begin
                        s_d.stage          = STG_IDLE;
                        cause.hit[CZ_DONE] = 1'b1;
                    end
                end
                STG_SEQ_ERR: begin
                    s_d = s_q;
                end
                default: begin
                    s_d.stage = STG_IDLE;
                    s_d.armed = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stage <= STG_IDLE;
            s_q.armed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stage = s_q.stage;

endmodule

// File: rtl/ctl_stage_irq.sv
module ctl_stage_irq
    import ctl_stage_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cause_t             cause,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic               flag,
    output logic [CAUSE_N-1:0] en
);
    localparam logic [ADDR_W-1:0] ADR_EN   = '0;
    localparam logic [ADDR_W-1:0] ADR_FLAG = ADDR_W'(1);

    irq_state_t         r_d, r_q;
    logic [CAUSE_N-1:0] masked;
    logic               set_ev;
    logic               clr_ev;

    generate
        for (genvar k = 0; k < CAUSE_N; k++) begin : g_mask
            assign masked[k] = cause.hit[k] & r_q.en[k];
        end
        if (DATA_W > CAUSE_N) begin : g_wd_spare
            logic unused_wd;
            assign unused_wd = ^reg_wdata[DATA_W-1:CAUSE_N];
        end
    endgenerate

    always_comb begin
        r_d    = r_q;
        set_ev = cause.setup_done | (|masked);
        clr_ev = reg_wr && (reg_addr == ADR_FLAG) && !reg_wdata[0];
        if (reg_wr && (reg_addr == ADR_EN))
            r_d.en = reg_wdata[CAUSE_N-1:0];
        if (clr_ev)
            r_d.flag = 1'b0;
        if (set_ev)
            r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en   <= '0;
            r_q.flag <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flag = r_q.flag;
    assign en   = r_q.en;

endmodule

// File: rtl/ctl_stage_tracker.sv
module ctl_stage_tracker
    import ctl_stage_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int RT_W   = 8,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_setup,
    input  logic              tok_in,
    input  logic              tok_out,
    input  logic              hs_ack,
    input  logic [RT_W-1:0]   req_type,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [2:0]        stage,
    output logic              xfer_irq,
    output logic              seq_err,
    output logic [3:0]        cause_en
);
    stage_e stage_w;
    cause_t cause_w;

    ctl_stage_seq #(
        .LEN_W (LEN_W),
        .RT_W  (RT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_setup (tok_setup),
        .tok_in    (tok_in),
        .tok_out   (tok_out),
        .hs_ack    (hs_ack),
        .req_type  (req_type),
        .req_len   (req_len),
        .stage     (stage_w),
        .cause     (cause_w)
    );

    ctl_stage_irq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause     (cause_w),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flag      (xfer_irq),
        .en        (cause_en)
    );

    assign stage   = stage_w;
    assign seq_err = (stage_w == STG_SEQ_ERR);

endmodule

// File: rtl/ctl_stage_tracker_chk.sv
module ctl_stage_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tok_setup,
    input logic       tok_in,
    input logic       tok_out,
    input logic       hs_ack,
    input logic       clr_wr,
    input logic [2:0] stage,
    input logic       xfer_irq,
    input logic [3:0] cause_en
);
    logic in_status;
    logic quiet_ack;

    assign in_status = (stage == 3'b010) || (stage == 3'b100) || (stage == 3'b101);
    assign quiet_ack = hs_ack && !tok_setup && !tok_in && !tok_out;

    p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stage != 3'b111);

    p_wr_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'b011 && tok_in && !tok_setup) |=> stage == 3'b100);

    p_rd_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'b001 && tok_out && !tok_setup) |=> stage == 3'b010);

    p_done_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_status && quiet_ack) |=> stage == 3'b000);

    p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_status && quiet_ack && cause_en[2]) |=> xfer_irq);

    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 3'b110 && !tok_setup) |=> stage == 3'b110);

    p_setup_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup |=> stage == 3'b000);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_irq && !clr_wr) |=> xfer_irq);

    p_rise_on_move_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_irq) |-> stage != $past(stage));

endmodule

bind ctl_stage_tracker ctl_stage_tracker_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_setup (tok_setup),
    .tok_in    (tok_in),
    .tok_out   (tok_out),
    .hs_ack    (hs_ack),
    .clr_wr    (reg_wr && (reg_addr == ADDR_W'(1)) && !reg_wdata[0]),
    .stage     (stage),
    .xfer_irq  (xfer_irq),
    .cause_en  (cause_en)
);

// File: tb/ctl_stage_tracker_tb.sv
`timescale 1ns/1ps
module ctl_stage_tracker_tb_top;
    localparam logic [2:0] S_IDLE = 3'd0, S_RDD = 3'd1, S_RDS = 3'd2, S_WRD = 3'd3,
                           S_WRS = 3'd4, S_NDS = 3'd5, S_ERR = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_setup = 1'b0, tok_in = 1'b0, tok_out = 1'b0, hs_ack = 1'b0;
    logic [7:0]  req_type = 8'h00;
    logic [15:0] req_len = 16'h0000;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [2:0]  stage;
    logic        xfer_irq, seq_err;
    logic [3:0]  cause_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ctl_stage_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_in(tok_in),
        .tok_out(tok_out), .hs_ack(hs_ack), .req_type(req_type), .req_len(req_len),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .stage(stage), .xfer_irq(xfer_irq), .seq_err(seq_err), .cause_en(cause_en)
    );

    task automatic step(input logic s, input logic i, input logic o, input logic a,
                        input logic clr);
        @(negedge clk);
        tok_setup = s; tok_in = i; tok_out = o; hs_ack = a;
        if (clr) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h00; end
        @(negedge clk);
        tok_setup = 1'b0; tok_in = 1'b0; tok_out = 1'b0; hs_ack = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [2:0] es, input logic ef);
        n_chk++;
        if (stage !== es || xfer_irq !== ef || seq_err !== (es == S_ERR)) begin
            n_fail++;
            $display("FAIL %s: stage=%0d flag=%0b err=%0b expected stage=%0d flag=%0b err=%0b",
                     tag, stage, xfer_irq, seq_err, es, ef, (es == S_ERR));
        end
    endtask

    task automatic chk_en(input string tag, input logic [3:0] ee);
        n_chk++;
        if (cause_en !== ee) begin
            n_fail++;
            $display("FAIL %s: cause_en=%b expected %b", tag, cause_en, ee);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", S_IDLE, 1'b0);
        chk_en("R1 reset mask", 4'b0000);
        // R6: token before any SETUP is an error (mask 0 -> flag stays 0)
        step(0, 1, 0, 0, 0); chk("R6 token in idle", S_ERR, 1'b0);

        for (int e = 0; e < 16; e++) begin
            logic [3:0] m;
            m = 4'(e);
            wr_reg(2'd0, {4'hF, m});
            chk_en("R10 mask load", m);

            // control read
            req_type = 8'hC0; req_len = 16'd8;
            step(0, 0, 0, 0, 1); chk("R8 clear", S_ERR, 1'b0);
            step(1, 0, 0, 0, 0); chk("R7 setup restart", S_IDLE, 1'b0);
            step(0, 0, 0, 1, 0); chk("R2 read route", S_RDD, 1'b1);
            wr_reg(2'd1, 8'h01); chk("R8 write one no effect", S_RDD, 1'b1);
            chk_en("R10 flag write keeps mask", m);
            step(0, 0, 0, 0, 1); chk("R8 clear", S_RDD, 1'b0);
            step(0, 1, 0, 0, 0); chk("R4 IN keeps read data", S_RDD, 1'b0);
            step(0, 0, 0, 1, 0); chk("R11 data ACK ignored", S_RDD, 1'b0);
            step(0, 0, 1, 0, 0); chk("R4 read status entry", S_RDS, m[1]);
            step(0, 0, 0, 0, 1);
            step(0, 0, 1, 0, 0); chk("R11 repeated OUT", S_RDS, 1'b0);
            step(0, 0, 0, 1, 0); chk("R5 read completion", S_IDLE, m[2]);
            step(0, 0, 0, 1, 0); chk("R11 idle ACK ignored", S_IDLE, m[2]);
            step(0, 0, 0, 0, 1);
            step(0, 1, 0, 0, 0); chk("R6 token after completion", S_ERR, m[3]);
            step(0, 0, 0, 0, 1);
            step(0, 0, 1, 0, 0); chk("R11 token in error stage", S_ERR, 1'b0);
            step(0, 0, 0, 1, 0); chk("R6 error holds", S_ERR, 1'b0);

            // control write, length with only upper bits set
            req_type = 8'h21; req_len = 16'h0100;
            step(1, 0, 0, 0, 0); chk("R7 setup from error", S_IDLE, 1'b0);
            step(0, 0, 0, 1, 0); chk("R2 write route", S_WRD, 1'b1);
            step(0, 0, 1, 0, 0); chk("R3 OUT keeps write data", S_WRD, 1'b1);
            step(0, 1, 0, 0, 1); chk("R9 set vs clear", S_WRS, m[0]);
            step(0, 0, 0, 0, 1);
            step(0, 1, 0, 0, 0); chk("R11 repeated IN", S_WRS, 1'b0);
            step(0, 0, 1, 0, 0); chk("R6 OUT in write status", S_ERR, m[3]);
            step(0, 0, 0, 0, 1);
            step(1, 0, 0, 0, 0);
            step(0, 0, 0, 1, 0); chk("R2 write route again", S_WRD, 1'b1);
            step(0, 0, 0, 0, 1);
            step(0, 1, 0, 0, 0); chk("R3 write status entry", S_WRS, m[0]);
            step(0, 0, 0, 0, 1);
            step(0, 0, 0, 1, 0); chk("R5 write completion", S_IDLE, m[2]);
            step(0, 0, 0, 0, 1);
            step(1, 0, 0, 0, 0);
            step(0, 0, 0, 1, 0); chk("R2 write route mid", S_WRD, 1'b1);
            step(1, 0, 0, 0, 0); chk("R7 restart mid transfer", S_IDLE, 1'b1);

            // no-data transfer
            req_type = 8'h80; req_len = 16'd0;
            step(0, 0, 0, 1, 1); chk("R9 setup ACK vs clear", S_NDS, 1'b1);
            step(0, 0, 0, 0, 1);
            step(0, 1, 0, 0, 0); chk("R11 IN in no-data status", S_NDS, 1'b0);
            step(0, 0, 0, 1, 0); chk("R5 no-data completion", S_IDLE, m[2]);
            step(0, 0, 0, 0, 1);
            step(1, 0, 0, 0, 0);
            step(0, 0, 0, 1, 0); chk("R2 no-data route", S_NDS, 1'b1);
            step(0, 0, 0, 0, 1);
            step(0, 0, 1, 0, 0); chk("R6 OUT in no-data status", S_ERR, m[3]);

            // read status hit by IN
            req_type = 8'h80; req_len = 16'd1;
            step(0, 0, 0, 0, 1);
            step(1, 0, 0, 0, 0);
            step(0, 0, 0, 1, 0); chk("R2 read route short", S_RDD, 1'b1);
            step(0, 0, 0, 0, 1);
            step(0, 0, 1, 0, 0); chk("R4 read status entry", S_RDS, m[1]);
            step(0, 0, 0, 0, 1);
            step(0, 1, 0, 0, 0); chk("R6 IN in read status", S_ERR, m[3]);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule